// File: doc/BRIEF.md
# Dual Halfword Multiply with Sum, Difference and Accumulate

This unit treats each of two 32-bit operands as a pair of signed 16-bit lanes. It multiplies the lanes pairwise and then either adds or subtracts the two 32-bit products. The combined value can be returned as it is, or added to an addend. That addend is either one 32-bit word or a 64-bit value supplied as a high word and a low word. The second operand's lanes may be exchanged before the multiplies. This gives the cross products used in complex arithmetic and in filter kernels.

The 32-bit forms update a sticky saturation-style overflow flag. The sum form can set the flag at two points: when the two products are added, and when the addend is added. The difference form can set it only when the addend is added. The 64-bit forms never change the flag. An accumulator selector equal to the reserved index (all ones) tells a 32-bit form to skip the addend. The unit also reports when a 64-bit form names the same register for both the high and the low destination. Results appear one clock after the input strobe.

Top module: `dmac_dual16`

## Requirements
- R1: Lane 0 is bits [15:0] and lane 1 is bits [31:16] of each operand. Both lanes are read as two's-complement values. The low product is lane 0 of A times lane 0 of B, and the high product is lane 1 of A times lane 1 of B.
- R2: When `swap` is 1, lane 0 of A is multiplied by lane 1 of B and lane 1 of A by lane 0 of B. Operand A is never exchanged.
- R3: In mode 2'b00 (sum, 32-bit) with `acc_sel` not 15, the result is low product + high product + `acc_lo`, modulo 2^32. The flag is set if the product sum has a signed overflow, or if adding `acc_lo` to that sum has a signed overflow.
- R4: In mode 2'b01 (difference, 32-bit) with `acc_sel` not 15, the result is low product − high product + `acc_lo`, modulo 2^32. Only the signed overflow of the final add sets the flag.
- R5: In the 32-bit modes, `acc_sel` equal to 15 ignores `acc_lo`. The sum form then flags only the overflow of the product sum. The difference form then leaves the flag unchanged.
- R6: In mode 2'b10 (sum, 64-bit) and mode 2'b11 (difference, 64-bit), each product is sign-extended to 64 bits, the two are added or subtracted, and {`acc_hi`,`acc_lo`} is added, modulo 2^64. The flag is left unchanged.
- R7: `dst_bad` is 1 with a result from a 64-bit mode in which `dst_lo` equals `dst_hi`. It is 0 for every 32-bit mode result, whatever the indices.
- R8: `out_valid` follows `in_valid` one cycle later. `res` and `dst_bad` change only after a cycle with `in_valid` high, and otherwise hold their values.
- R9: The flag is sticky: once set, it stays set until `clr_flag` is applied. An overflow accepted in the same cycle as `clr_flag` leaves the flag set.
- R10: After a synchronous active-low reset, `out_valid`, `res`, `ovf_flag` and `dst_bad` are all 0.
- R11: A 32-bit mode places its result in `res[31:0]` and drives `res[63:32]` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_flag | input | 1 | Clears the sticky overflow flag |
| in_valid | input | 1 | Strobe that accepts the operation |
| mode | input | 2 | 00 sum32, 01 diff32, 10 sum64, 11 diff64 |
| swap | input | 1 | Exchange the lanes of operand B |
| op_a | input | 32 | Operand A, two signed 16-bit lanes |
| op_b | input | 32 | Operand B, two signed 16-bit lanes |
| acc_sel | input | 4 | Accumulator index; 15 disables the 32-bit addend |
| acc_lo | input | 32 | 32-bit addend, or low word of the 64-bit addend |
| acc_hi | input | 32 | High word of the 64-bit addend |
| dst_lo | input | 4 | Low destination index (64-bit forms) |
| dst_hi | input | 4 | High destination index (64-bit forms) |
| out_valid | output | 1 | Result valid |
| res | output | 64 | Result |
| ovf_flag | output | 1 | Sticky overflow flag |
| dst_bad | output | 1 | Equal destination indices in a 64-bit form |

## Verification
A wrong lane selection or a wrong exchange produces a wrong `res` on the cycle right after the strobe. The vectors therefore use lanes with distinct values and signs, so that any misrouted lane changes the number. Faults in the overflow logic show up only in `ovf_flag`, also one cycle later. Because the flag is sticky, every overflow scenario starts from a cleared flag. The scenarios separate the three possible sources: the product-sum step, the addend step, and the 64-bit path that must stay silent. A wrong held value of `res` or `dst_bad` is caught by looking at the outputs on a cycle without a strobe.

// File: rtl/dmac_pkg.sv
// Shared definitions for the dual halfword multiply unit.
// Assumes a two-bit mode field, whose upper bit selects the 64-bit path.
package dmac_pkg;
    typedef enum logic [1:0] {
        DM_SUM_W = 2'b00,
        DM_DIF_W = 2'b01,
        DM_SUM_L = 2'b10,
        DM_DIF_L = 2'b11
    } dm_mode_e;
endpackage

// File: rtl/dmac_lane_mul.sv
// Splits both operands into signed lanes, optionally exchanges the lanes
// of operand B, and forms one signed product per lane.
// Assumes the lane products fit in twice the lane width.
module dmac_lane_mul #(
    parameter int HALF_W = 16,
    localparam int WORD_W = 2 * HALF_W
) (
    input  logic [WORD_W-1:0]      op_a,
    input  logic [WORD_W-1:0]      op_b,
    input  logic                   swap,
    output logic [1:0][WORD_W-1:0] prod
);
    // One multiplier per lane; the exchange picks the opposite lane of B.
    for (genvar g = 0; g < 2; g++) begin : g_lane
        logic [HALF_W-1:0] a_h, b_h;
        always_comb begin
            a_h = op_a[g*HALF_W +: HALF_W];
            b_h = swap ? op_b[(1-g)*HALF_W +: HALF_W] : op_b[g*HALF_W +: HALF_W];
            prod[g] = WORD_W'($signed(a_h) * $signed(b_h));
        end
    end
endmodule

// File: rtl/dmac_combine.sv
// Adds or subtracts the two lane products and applies the addend for the
// selected width. Reports the signed overflow of the 32-bit forms.
// Assumes use_acc is ignored by the 64-bit forms, which always accumulate.
module dmac_combine
    import dmac_pkg::*;
#(
    parameter int HALF_W = 16,
    localparam int WORD_W = 2 * HALF_W,
    localparam int LONG_W = 2 * WORD_W
) (
    input  logic [WORD_W-1:0] p_lo,
    input  logic [WORD_W-1:0] p_hi,
    input  logic [1:0]        mode,
    input  logic              use_acc,
    input  logic [WORD_W-1:0] acc_lo,
    input  logic [WORD_W-1:0] acc_hi,
    output logic [LONG_W-1:0] result,
    output logic              ovf
);
    localparam int MSB = WORD_W - 1;

    logic              is_long, is_diff;
    logic [WORD_W-1:0] sum_w, mid_w, add_w, fin_w;
    logic [LONG_W-1:0] plo_l, phi_l, mid_l, fin_l;
    logic              ovf_sum, ovf_acc;

    // Word-width path with per-step signed overflow detection.
    always_comb begin
        is_long = mode[1];
        is_diff = mode[0];
        sum_w   = p_lo + p_hi;
        ovf_sum = (p_lo[MSB] == p_hi[MSB]) && (sum_w[MSB] != p_lo[MSB]);
        mid_w   = is_diff ? (p_lo - p_hi) : sum_w;
        add_w   = use_acc ? acc_lo : '0;
        fin_w   = mid_w + add_w;
        ovf_acc = use_acc && (mid_w[MSB] == add_w[MSB]) && (fin_w[MSB] != mid_w[MSB]);
    end

    // Long path: sign-extended products plus the {high,low} addend.
    always_comb begin
        plo_l = {{WORD_W{p_lo[MSB]}}, p_lo};
        phi_l = {{WORD_W{p_hi[MSB]}}, p_hi};
        mid_l = is_diff ? (plo_l - phi_l) : (plo_l + phi_l);
        fin_l = mid_l + {acc_hi, acc_lo};
    end

    // Final selection; only the word forms may raise overflow.
    always_comb begin
        result = is_long ? fin_l : {{WORD_W{1'b0}}, fin_w};
        ovf    = !is_long && ((!is_diff && ovf_sum) || ovf_acc);
    end
endmodule

// File: rtl/dmac_dual16.sv
// Top of the dual halfword multiply unit: one register stage holds the
// result, the destination check and the sticky overflow flag.
// Assumes clr_flag may arrive together with in_valid; a new overflow wins.
module dmac_dual16
    import dmac_pkg::*;
#(
    parameter int HALF_W = 16,
    parameter int IDX_W  = 4,
    localparam int WORD_W = 2 * HALF_W,
    localparam int LONG_W = 2 * WORD_W,
    localparam logic [IDX_W-1:0] NO_ACC_IDX = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_flag,
    input  logic              in_valid,
    input  logic [1:0]        mode,
    input  logic              swap,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic [IDX_W-1:0]  acc_sel,
    input  logic [WORD_W-1:0] acc_lo,
    input  logic [WORD_W-1:0] acc_hi,
    input  logic [IDX_W-1:0]  dst_lo,
    input  logic [IDX_W-1:0]  dst_hi,
    output logic              out_valid,
    output logic [LONG_W-1:0] res,
    output logic              ovf_flag,
    output logic              dst_bad
);
    logic [1:0][WORD_W-1:0] prod;
    logic [LONG_W-1:0]      comb_res;
    logic                   comb_ovf;
    logic                   use_acc, bad_now;

    dmac_lane_mul #(.HALF_W(HALF_W)) u_mul (
        .op_a (op_a),
        .op_b (op_b),
        .swap (swap),
        .prod (prod)
    );

    dmac_combine #(.HALF_W(HALF_W)) u_comb (
        .p_lo    (prod[0]),
        .p_hi    (prod[1]),
        .mode    (mode),
        .use_acc (use_acc),
        .acc_lo  (acc_lo),
        .acc_hi  (acc_hi),
        .result  (comb_res),
        .ovf     (comb_ovf)
    );

    // Reserved accumulator index and equal-destination decode.
    always_comb begin
        use_acc = (acc_sel != NO_ACC_IDX);
        bad_now = mode[1] && (dst_lo == dst_hi);
    end

    // Output stage: valid, result, destination check and sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            res       <= '0;
            dst_bad   <= 1'b0;
            ovf_flag  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                res     <= comb_res;
                dst_bad <= bad_now;
            end
            ovf_flag <= (ovf_flag && !clr_flag) || (in_valid && comb_ovf);
        end
    end
endmodule

// File: rtl/dmac_dual16_chk.sv
// Checker for the dual halfword multiply unit, bound to every instance.
// Assumes the top module's port names and the synchronous active-low reset.
module dmac_dual16_chk #(
    parameter int HALF_W = 16,
    parameter int IDX_W  = 4,
    localparam int WORD_W = 2 * HALF_W,
    localparam int LONG_W = 2 * WORD_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr_flag,
    input logic              in_valid,
    input logic [1:0]        mode,
    input logic [IDX_W-1:0]  acc_sel,
    input logic              out_valid,
    input logic [LONG_W-1:0] res,
    input logic              ovf_flag,
    input logic              dst_bad
);
    p_valid_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_res_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(res) && $stable(dst_bad));
    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !clr_flag) |=> ovf_flag);
    p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_flag && !in_valid) |=> !ovf_flag);
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode[1] && !ovf_flag) |=> !ovf_flag);
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'b01 && acc_sel == '1 && !ovf_flag) |=> !ovf_flag);
    p_bad_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mode[1]) |=> !dst_bad);
    p_upper_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mode[1]) |=> res[LONG_W-1:WORD_W] == '0);
    p_reset_r10: assert property (@(posedge clk)
        !rst_n |=> !out_valid && !ovf_flag && !dst_bad && res == '0);
endmodule

bind dmac_dual16 dmac_dual16_chk #(.HALF_W(HALF_W), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_flag  (clr_flag),
    .in_valid  (in_valid),
    .mode      (mode),
    .acc_sel   (acc_sel),
    .out_valid (out_valid),
    .res       (res),
    .ovf_flag  (ovf_flag),
    .dst_bad   (dst_bad)
);

// File: tb/dmac_dual16_tb.sv
module dmac_dual16_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr_flag = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic        swap = 1'b0;
    logic [31:0] op_a = '0, op_b = '0, acc_lo = '0, acc_hi = '0;
    logic [3:0]  acc_sel = 4'd15, dst_lo = 4'd0, dst_hi = 4'd1;
    logic        out_valid, ovf_flag, dst_bad;
    logic [63:0] res;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    dmac_dual16 u_dut (
        .clk(clk), .rst_n(rst_n), .clr_flag(clr_flag), .in_valid(in_valid),
        .mode(mode), .swap(swap), .op_a(op_a), .op_b(op_b), .acc_sel(acc_sel),
        .acc_lo(acc_lo), .acc_hi(acc_hi), .dst_lo(dst_lo), .dst_hi(dst_hi),
        .out_valid(out_valid), .res(res), .ovf_flag(ovf_flag), .dst_bad(dst_bad)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issue one operation and sample just after the capturing edge.
    task automatic issue(input logic [1:0] m, input logic sw, input logic [31:0] a,
                         input logic [31:0] b, input logic [3:0] sel,
                         input logic [31:0] lo, input logic [31:0] hi,
                         input logic [3:0] dl, input logic [3:0] dh, input logic clr);
        @(negedge clk);
        mode = m; swap = sw; op_a = a; op_b = b; acc_sel = sel;
        acc_lo = lo; acc_hi = hi; dst_lo = dl; dst_hi = dh;
        clr_flag = clr; in_valid = 1'b1;
        @(posedge clk);
        #1;
        in_valid = 1'b0; clr_flag = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk);
        clr_flag = 1'b1;
        @(posedge clk);
        #1;
        clr_flag = 1'b0;
    endtask

    task automatic t_reset();
        check("R10 out_valid", 64'(out_valid), 64'd0);
        check("R10 res", res, 64'd0);
        check("R10 flag", 64'(ovf_flag), 64'd0);
        check("R10 dst_bad", 64'(dst_bad), 64'd0);
    endtask

    task automatic t_split();
        issue(2'b00, 1'b0, 32'h0003_FFFE, 32'h0005_0004, 4'd15, 32'd999, 32'd0, 4'd1, 4'd1, 1'b0);
        check("R1 R11 mixed signs", res, 64'h0000_0000_0000_0007);
        check("R1 flag", 64'(ovf_flag), 64'd0);
        issue(2'b00, 1'b0, 32'hFFFF_0002, 32'h8000_7FFF, 4'd15, 32'd0, 32'd0, 4'd1, 4'd2, 1'b0);
        check("R1 R11 extreme lanes", res, 64'h0000_0000_0001_7FFE);
    endtask

    task automatic t_swap();
        issue(2'b00, 1'b1, 32'h0003_FFFE, 32'h0005_0004, 4'd15, 32'd0, 32'd0, 4'd1, 4'd2, 1'b0);
        check("R2 exchanged", res, 64'd2);
    endtask

    task automatic t_sum_acc();
        issue(2'b00, 1'b0, 32'h0003_FFFE, 32'h0005_0004, 4'd2, 32'd100, 32'd0, 4'd1, 4'd2, 1'b0);
        check("R3 sum acc", res, 64'h6B);
        check("R3 no ovf", 64'(ovf_flag), 64'd0);
        issue(2'b00, 1'b0, 32'h8000_8000, 32'h8000_8000, 4'd0, 32'd1, 32'd0, 4'd1, 4'd2, 1'b0);
        check("R3 product-sum step", res, 64'h8000_0001);
        check("R3 flag from product sum", 64'(ovf_flag), 64'd1);
        clear_flag();
        issue(2'b00, 1'b0, 32'h7FFF_7FFF, 32'h7FFF_7FFF, 4'd0, 32'h1000_0000, 32'd0, 4'd1, 4'd2, 1'b0);
        check("R3 addend step", res, 64'h8FFE_0002);
        check("R3 flag from addend", 64'(ovf_flag), 64'd1);
        clear_flag();
    endtask

    task automatic t_dif_acc();
        issue(2'b01, 1'b0, 32'h0003_FFFE, 32'h0005_0004, 4'd3, 32'd100, 32'd0, 4'd1, 4'd2, 1'b0);
        check("R4 diff acc", res, 64'h4D);
        check("R4 no ovf", 64'(ovf_flag), 64'd0);
        issue(2'b01, 1'b0, 32'h8000_8000, 32'h8000_8000, 4'd3, 32'd0, 32'd0, 4'd1, 4'd2, 1'b0);
        check("R4 equal products no flag", 64'(ovf_flag), 64'd0);
        issue(2'b01, 1'b0, 32'h0000_8000, 32'h0000_8000, 4'd3, 32'h4000_0000, 32'd0, 4'd1, 4'd2, 1'b0);
        check("R4 final add wraps", res, 64'h8000_0000);
        check("R4 flag from final add", 64'(ovf_flag), 64'd1);
        clear_flag();
    endtask

    task automatic t_no_acc();
        issue(2'b01, 1'b0, 32'h0000_8000, 32'h0000_8000, 4'd15, 32'h4000_0000, 32'd0, 4'd1, 4'd2, 1'b0);
        check("R5 diff addend ignored", res, 64'h4000_0000);
        check("R5 diff no flag", 64'(ovf_flag), 64'd0);
        issue(2'b00, 1'b0, 32'h8000_8000, 32'h8000_8000, 4'd15, 32'h7FFF_FFFF, 32'd0, 4'd1, 4'd2, 1'b0);
        check("R5 sum addend ignored", res, 64'h8000_0000);
        check("R5 sum flags product sum", 64'(ovf_flag), 64'd1);
        clear_flag();
    endtask

    task automatic t_long();
        issue(2'b10, 1'b0, 32'h0003_FFFE, 32'h0005_0004, 4'd15, 32'hFFFF_FFFF, 32'h0000_0001, 4'd1, 4'd2, 1'b0);
        check("R6 sum64 carry into high", res, 64'h0000_0002_0000_0006);
        issue(2'b11, 1'b0, 32'h0003_FFFE, 32'h0005_0004, 4'd2, 32'd0, 32'd0, 4'd1, 4'd2, 1'b0);
        check("R6 diff64 negative", res, 64'hFFFF_FFFF_FFFF_FFE9);
        issue(2'b10, 1'b0, 32'h8000_8000, 32'h8000_8000, 4'd0, 32'd0, 32'd0, 4'd1, 4'd2, 1'b0);
        check("R6 sum64 no wrap", res, 64'h0000_0000_8000_0000);
        check("R6 flag unchanged", 64'(ovf_flag), 64'd0);
    endtask

    task automatic t_bad_dest();
        issue(2'b10, 1'b0, 32'd1, 32'd1, 4'd0, 32'd0, 32'd0, 4'd3, 4'd3, 1'b0);
        check("R7 equal dest 64-bit", 64'(dst_bad), 64'd1);
        issue(2'b00, 1'b0, 32'd1, 32'd1, 4'd0, 32'd0, 32'd0, 4'd3, 4'd3, 1'b0);
        check("R7 equal dest 32-bit", 64'(dst_bad), 64'd0);
        issue(2'b11, 1'b0, 32'd1, 32'd1, 4'd0, 32'd0, 32'd0, 4'd3, 4'd4, 1'b0);
        check("R7 distinct dest 64-bit", 64'(dst_bad), 64'd0);
    endtask

    task automatic t_latency();
        issue(2'b00, 1'b0, 32'h0003_FFFE, 32'h0005_0004, 4'd15, 32'd0, 32'd0, 4'd1, 4'd2, 1'b0);
        check("R8 valid after strobe", 64'(out_valid), 64'd1);
        @(negedge clk);
        op_a = 32'h1234_5678; op_b = 32'h7FFF_7FFF; mode = 2'b10;
        dst_lo = 4'd5; dst_hi = 4'd5;
        @(posedge clk);
        #1;
        check("R8 valid drops", 64'(out_valid), 64'd0);
        check("R8 result held", res, 64'd7);
        check("R8 dst_bad held", 64'(dst_bad), 64'd0);
    endtask

    task automatic t_sticky();
        issue(2'b00, 1'b0, 32'h8000_8000, 32'h8000_8000, 4'd15, 32'd0, 32'd0, 4'd1, 4'd2, 1'b0);
        issue(2'b00, 1'b0, 32'd1, 32'd1, 4'd15, 32'd0, 32'd0, 4'd1, 4'd2, 1'b0);
        check("R9 flag stays set", 64'(ovf_flag), 64'd1);
        issue(2'b00, 1'b0, 32'h8000_8000, 32'h8000_8000, 4'd15, 32'd0, 32'd0, 4'd1, 4'd2, 1'b1);
        check("R9 overflow beats clear", 64'(ovf_flag), 64'd1);
        issue(2'b00, 1'b0, 32'd1, 32'd1, 4'd15, 32'd0, 32'd0, 4'd1, 4'd2, 1'b1);
        check("R9 clear with quiet op", 64'(ovf_flag), 64'd0);
        issue(2'b00, 1'b0, 32'h8000_8000, 32'h8000_8000, 4'd15, 32'd0, 32'd0, 4'd1, 4'd2, 1'b0);
        clear_flag();
        check("R9 clear alone", 64'(ovf_flag), 64'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_split();
        t_swap();
        t_sum_acc();
        t_dif_acc();
        t_no_acc();
        t_long();
        t_bad_dest();
        t_latency();
        t_sticky();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R8 watchdog actual=hang expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule